// File: doc/BRIEF.md
# Indirect Switch Register Bridge

This block lets a host read and write 32-bit registers of an Ethernet switch that is reachable only through a management bus master doing 16-bit accesses. For each host request it breaks the switch register address into two parts. The upper address bits become a page value, which is written to a page-select location. The lower bits pick a pseudo-PHY address and a register pair inside that page. The block then performs two 16-bit accesses, one for each half of the word, and either assembles the read data or splits the write data.

A two-bit model input selects where the page-select location lives. In model A, one register (address 0x98) must receive its low half before its high half. If any sub-access reports an error, the sequence stops at once and the error is returned to the host. The bridge talks to the management bus master through a request/acknowledge interface and never has more than one transaction outstanding.

Top module: `sw_reg_bridge`

## Requirements
- R1: The first management access of every valid request is a write of the page value `addr >> 9`. For model A (`host_model_i` = 0) it goes to PHY 0x1F, register 0x10. For model B (`host_model_i` = 1) it goes to PHY 0x18, register 0x00.
- R2: Both data accesses use PHY `0x10 | addr[8:6]`. The register number is `{addr[5:2], h}`, where h = 0 selects the low half and h = 1 selects the high half.
- R3: A read fetches the low half (h = 0) and then the high half (h = 1). It returns `{high, low}` on `host_rdata_o`.
- R4: A write normally sends `wdata[31:16]` to h = 1 first and `wdata[15:0]` to h = 0 second.
- R5: In model A, a write to address 0x98 sends the low half first and the high half second. Model B writes to 0x98 use the normal order, and reads of 0x98 keep the read order.
- R6: A sub-access acknowledged with `mdio_err_i` = 1 ends the request with `host_err_o` = 1. No further management request is issued for that host request.
- R7: A model value of 2 or 3 completes with `host_err_o` = 1 and issues no management access. `host_ack_o` is seen on the second clock edge after acceptance.
- R8: While `mdio_req_o` is high and not yet acknowledged, PHY, register, write data and direction stay stable. Exactly the expected number of sub-accesses is issued.
- R9: `host_ack_o` is a one-cycle pulse, asserted in the cycle after the final sub-access acknowledge. Host inputs are captured at acceptance, so changing them during a request has no effect.
- R10: After reset, `host_ack_o` and `mdio_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | Host request; accepted when the bridge is idle, dropped on ack |
| host_addr_i | input | ADDR_W | Switch register byte address |
| host_wdata_i | input | 32 | Write data |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_model_i | input | 2 | 0 = model A, 1 = model B, others invalid |
| host_ack_o | output | 1 | Completion pulse |
| host_rdata_o | output | 32 | Read data, valid with ack on a successful read |
| host_err_o | output | 1 | Error flag, valid with ack |
| mdio_req_o | output | 1 | Management access request |
| mdio_phy_o | output | 5 | PHY address |
| mdio_reg_o | output | 5 | Register number |
| mdio_wdata_o | output | 16 | Write data |
| mdio_we_o | output | 1 | 1 = write access |
| mdio_ack_i | input | 1 | Access complete |
| mdio_rdata_i | input | 16 | Read data, valid with ack |
| mdio_err_i | input | 1 | Access failed, valid with ack |

## Verification
The assertions assume three things about the inputs:
- The management master raises `mdio_ack_i` only while `mdio_req_o` is high, and for a single cycle per access.
- The host holds its request until it sees `host_ack_o`.
- The host drops the request in the same cycle it sees `host_ack_o`.

The bench responder acknowledges only a pending request, after a programmable wait, and clears the acknowledge on the next cycle. The host tasks release the request in the cycle they observe the completion pulse. Error injection picks one sub-access index per request, so an error never arrives outside an acknowledge.

// File: rtl/sw_bridge_pkg.sv
package sw_bridge_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int HALF_W = 16;

  localparam logic [1:0] MODEL_A = 2'd0;
  localparam logic [1:0] MODEL_B = 2'd1;

  localparam logic [PHY_W-1:0] PAGE_PHY_A  = 5'h1F;
  localparam logic [REG_W-1:0] PAGE_REG_A  = 5'h10;
  localparam logic [PHY_W-1:0] PAGE_PHY_B  = 5'h18;
  localparam logic [REG_W-1:0] PAGE_REG_B  = 5'h00;
  localparam logic [PHY_W-1:0] PSEUDO_BASE = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_FIRST,
    ST_SECOND,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/sw_bridge_xlate.sv
module sw_bridge_xlate
  import sw_bridge_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter logic [ADDR_W-1:0] SWAP_ADDR = ADDR_W'('h98)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        model_i,
  output logic [PHY_W-1:0]  page_phy_o,
  output logic [REG_W-1:0]  page_reg_o,
  output logic [HALF_W-1:0] page_val_o,
  output logic [PHY_W-1:0]  data_phy_o,
  output logic [REG_W-1:0]  data_reg_o,
  output logic              low_first_o,
  output logic              model_ok_o
);
  localparam int PAGE_SHIFT = 9;

  always_comb begin
    page_phy_o = PAGE_PHY_A;
    page_reg_o = PAGE_REG_A;
    model_ok_o = 1'b1;
    unique case (model_i)
      MODEL_A: begin
        page_phy_o = PAGE_PHY_A;
        page_reg_o = PAGE_REG_A;
      end
      MODEL_B: begin
        page_phy_o = PAGE_PHY_B;
        page_reg_o = PAGE_REG_B;
      end
      default: model_ok_o = 1'b0;
    endcase
  end

  assign page_val_o  = HALF_W'(addr_i >> PAGE_SHIFT);
  assign data_phy_o  = PSEUDO_BASE | {2'b00, addr_i[8:6]};
  // half-select bit left at zero; sequencer sets it
  assign data_reg_o  = {addr_i[5:2], 1'b0};
  assign low_first_o = (model_i == MODEL_A) && (addr_i == SWAP_ADDR);
endmodule

// File: rtl/sw_bridge_seq.sv
module sw_bridge_seq
  import sw_bridge_pkg::*;
#(
  parameter int ADDR_W = 18,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_model_i,
  output logic              host_ack_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_err_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [1:0]        cap_model_o,
  input  logic [PHY_W-1:0]  page_phy_i,
  input  logic [REG_W-1:0]  page_reg_i,
  input  logic [HALF_W-1:0] page_val_i,
  input  logic [PHY_W-1:0]  data_phy_i,
  input  logic [REG_W-1:0]  data_reg_i,
  input  logic              low_first_i,
  input  logic              model_ok_i,
  output logic              mdio_req_o,
  output logic [PHY_W-1:0]  mdio_phy_o,
  output logic [REG_W-1:0]  mdio_reg_o,
  output logic [HALF_W-1:0] mdio_wdata_o,
  output logic              mdio_we_o,
  input  logic              mdio_ack_i,
  input  logic [HALF_W-1:0] mdio_rdata_i,
  input  logic              mdio_err_i
);
  seq_state_e        state_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              active;
  logic              first_low;
  logic              half_sel;

  assign active     = (state_q == ST_PAGE) || (state_q == ST_FIRST) || (state_q == ST_SECOND);
  assign mdio_req_o = active && model_ok_i;
  // reads and normal writes differ in which half goes first
  assign first_low  = !we_q || low_first_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cap_addr_o  <= '0;
      cap_model_o <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (host_req_i) begin
          cap_addr_o  <= host_addr_i;
          cap_model_o <= host_model_i;
          we_q        <= host_we_i;
          wdata_q     <= host_wdata_i;
          rdata_q     <= '0;
          err_q       <= 1'b0;
          state_q     <= ST_PAGE;
        end
        ST_PAGE: begin
          if (!model_ok_i) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (mdio_ack_i) begin
            if (mdio_err_i) begin
              err_q   <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_FIRST;
            end
          end
        end
        ST_FIRST: if (mdio_ack_i) begin
          if (mdio_err_i) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            if (!we_q) rdata_q[HALF_W-1:0] <= mdio_rdata_i;
            state_q <= ST_SECOND;
          end
        end
        ST_SECOND: if (mdio_ack_i) begin
          if (mdio_err_i) err_q <= 1'b1;
          else if (!we_q) rdata_q[DATA_W-1:HALF_W] <= mdio_rdata_i;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    half_sel = 1'b0;
    unique case (state_q)
      ST_FIRST:  half_sel = !first_low;
      ST_SECOND: half_sel = first_low;
      default:   half_sel = 1'b0;
    endcase
  end

  always_comb begin
    if (state_q == ST_PAGE) begin
      mdio_phy_o   = page_phy_i;
      mdio_reg_o   = page_reg_i;
      mdio_wdata_o = page_val_i;
      mdio_we_o    = 1'b1;
    end else begin
      mdio_phy_o   = data_phy_i;
      mdio_reg_o   = data_reg_i | REG_W'(half_sel);
      mdio_wdata_o = !we_q ? '0 : (half_sel ? wdata_q[DATA_W-1:HALF_W] : wdata_q[HALF_W-1:0]);
      mdio_we_o    = we_q;
    end
  end

  assign host_ack_o   = (state_q == ST_DONE);
  assign host_rdata_o = rdata_q;
  assign host_err_o   = err_q;
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
  import sw_bridge_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [31:0]       host_wdata_i,
  input  logic              host_we_i,
  input  logic [1:0]        host_model_i,
  output logic              host_ack_o,
  output logic [31:0]       host_rdata_o,
  output logic              host_err_o,
  output logic              mdio_req_o,
  output logic [4:0]        mdio_phy_o,
  output logic [4:0]        mdio_reg_o,
  output logic [15:0]       mdio_wdata_o,
  output logic              mdio_we_o,
  input  logic              mdio_ack_i,
  input  logic [15:0]       mdio_rdata_i,
  input  logic              mdio_err_i
);
  logic [ADDR_W-1:0] cap_addr;
  logic [1:0]        cap_model;
  logic [PHY_W-1:0]  page_phy, data_phy;
  logic [REG_W-1:0]  page_reg, data_reg;
  logic [HALF_W-1:0] page_val;
  logic              low_first, model_ok;

  sw_bridge_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .addr_i      (cap_addr),
    .model_i     (cap_model),
    .page_phy_o  (page_phy),
    .page_reg_o  (page_reg),
    .page_val_o  (page_val),
    .data_phy_o  (data_phy),
    .data_reg_o  (data_reg),
    .low_first_o (low_first),
    .model_ok_o  (model_ok)
  );

  sw_bridge_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_req_i   (host_req_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_we_i    (host_we_i),
    .host_model_i (host_model_i),
    .host_ack_o   (host_ack_o),
    .host_rdata_o (host_rdata_o),
    .host_err_o   (host_err_o),
    .cap_addr_o   (cap_addr),
    .cap_model_o  (cap_model),
    .page_phy_i   (page_phy),
    .page_reg_i   (page_reg),
    .page_val_i   (page_val),
    .data_phy_i   (data_phy),
    .data_reg_i   (data_reg),
    .low_first_i  (low_first),
    .model_ok_i   (model_ok),
    .mdio_req_o   (mdio_req_o),
    .mdio_phy_o   (mdio_phy_o),
    .mdio_reg_o   (mdio_reg_o),
    .mdio_wdata_o (mdio_wdata_o),
    .mdio_we_o    (mdio_we_o),
    .mdio_ack_i   (mdio_ack_i),
    .mdio_rdata_i (mdio_rdata_i),
    .mdio_err_i   (mdio_err_i)
  );
endmodule

// File: rtl/sw_reg_bridge_chk.sv
module sw_reg_bridge_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_req_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [31:0]       host_wdata_i,
  input logic              host_we_i,
  input logic [1:0]        host_model_i,
  input logic              host_ack_o,
  input logic [31:0]       host_rdata_o,
  input logic              host_err_o,
  input logic              mdio_req_o,
  input logic [4:0]        mdio_phy_o,
  input logic [4:0]        mdio_reg_o,
  input logic [15:0]       mdio_wdata_o,
  input logic              mdio_we_o,
  input logic              mdio_ack_i,
  input logic [15:0]       mdio_rdata_i,
  input logic              mdio_err_i
);
  // R8
  fields_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && !mdio_ack_i |=> mdio_req_o && $stable(mdio_phy_o) && $stable(mdio_reg_o)
      && $stable(mdio_wdata_o) && $stable(mdio_we_o));

  // R1
  page_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_req_o) |-> mdio_we_o &&
      ((mdio_phy_o == 5'h1F && mdio_reg_o == 5'h10) || (mdio_phy_o == 5'h18 && mdio_reg_o == 5'h00)));

  // R9
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |=> !host_ack_o);

  // R9
  ack_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> !mdio_req_o);

  // R6
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && mdio_ack_i && mdio_err_i |=> !mdio_req_o && host_ack_o && host_err_o);
endmodule

bind sw_reg_bridge sw_reg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sw_reg_bridge_test.sv
module sw_reg_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              host_req_i = 1'b0;
  logic [ADDR_W-1:0] host_addr_i = '0;
  logic [31:0]       host_wdata_i = '0;
  logic              host_we_i = 1'b0;
  logic [1:0]        host_model_i = '0;
  logic              host_ack_o;
  logic [31:0]       host_rdata_o;
  logic              host_err_o;
  logic              mdio_req_o;
  logic [4:0]        mdio_phy_o;
  logic [4:0]        mdio_reg_o;
  logic [15:0]       mdio_wdata_o;
  logic              mdio_we_o;
  logic              mdio_ack_i = 1'b0;
  logic [15:0]       mdio_rdata_i = '0;
  logic              mdio_err_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int n_seen = 0;
  int err_inject = -1;
  int lat = 0;
  int wcnt = 0;
  bit op_active = 1'b0;
  string cur_tag = "R1";
  logic [26:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_reg_bridge #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .host_req_i(host_req_i), .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
    .host_we_i(host_we_i), .host_model_i(host_model_i),
    .host_ack_o(host_ack_o), .host_rdata_o(host_rdata_o), .host_err_o(host_err_o),
    .mdio_req_o(mdio_req_o), .mdio_phy_o(mdio_phy_o), .mdio_reg_o(mdio_reg_o),
    .mdio_wdata_o(mdio_wdata_o), .mdio_we_o(mdio_we_o),
    .mdio_ack_i(mdio_ack_i), .mdio_rdata_i(mdio_rdata_i), .mdio_err_i(mdio_err_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rsp_fn(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'h15} ^ 16'h5A3C;
  endfunction

  // reference responder: compares the pending access every clock, acks after lat waits
  always @(negedge clk) begin
    if (mdio_ack_i) begin
      mdio_ack_i = 1'b0;
      mdio_err_i = 1'b0;
    end else if (rst_ni && mdio_req_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected management request", 32'({mdio_phy_o, mdio_reg_o}), 32'h0);
      end else begin
        logic [26:0] obs;
        obs = {mdio_we_o, mdio_phy_o, mdio_reg_o, mdio_we_o ? mdio_wdata_o : 16'h0};
        chk(obs == exp_q[0], cur_tag, "management access fields", 32'(obs), 32'(exp_q[0]));
      end
      if (wcnt >= lat) begin
        mdio_ack_i   = 1'b1;
        mdio_rdata_i = rsp_fn(mdio_phy_o, mdio_reg_o);
        mdio_err_i   = (n_seen == err_inject);
        n_seen++;
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !op_active && (host_ack_o || mdio_req_o))
      chk(1'b0, "R9", "activity with no request", 32'({host_ack_o, mdio_req_o}), 32'h0);
  end

  task automatic host_op(input logic [ADDR_W-1:0] a, input logic [31:0] wd, input logic we,
                         input logic [1:0] model, input int err_at, input int lat_in,
                         input string tag, input bit scramble);
    logic [4:0]  dphy, rb;
    logic [31:0] exp_rd;
    bit          exp_err;
    int          n_exp;
    int          cyc;
    bit          valid;
    exp_q.delete();
    valid = (model < 2);
    dphy  = 5'h10 | {2'b00, a[8:6]};
    rb    = {a[5:2], 1'b0};
    exp_rd = {rsp_fn(dphy, rb | 5'd1), rsp_fn(dphy, rb)};
    if (valid) begin
      exp_q.push_back({1'b1, (model == 0) ? 5'h1F : 5'h18, (model == 0) ? 5'h10 : 5'h00,
                       16'(a >> 9)});
      if (!we) begin
        exp_q.push_back({1'b0, dphy, rb, 16'h0});
        exp_q.push_back({1'b0, dphy, rb | 5'd1, 16'h0});
      end else if (model == 0 && a == ADDR_W'('h98)) begin
        exp_q.push_back({1'b1, dphy, rb, wd[15:0]});
        exp_q.push_back({1'b1, dphy, rb | 5'd1, wd[31:16]});
      end else begin
        exp_q.push_back({1'b1, dphy, rb | 5'd1, wd[31:16]});
        exp_q.push_back({1'b1, dphy, rb, wd[15:0]});
      end
    end
    exp_err = !valid;
    if (valid && err_at >= 0 && err_at < exp_q.size()) begin
      while (exp_q.size() > err_at + 1) void'(exp_q.pop_back());
      exp_err = 1'b1;
    end
    n_exp = exp_q.size();
    n_seen = 0; err_inject = err_at; lat = lat_in; wcnt = 0; cur_tag = tag;

    @(negedge clk);
    op_active = 1'b1;
    host_addr_i = a; host_wdata_i = wd; host_we_i = we; host_model_i = model;
    host_req_i = 1'b1;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (scramble && cyc == 1) begin
        host_addr_i = ~a; host_wdata_i = ~wd; host_we_i = ~we; host_model_i = 2'd3;
      end
      if (host_ack_o) break;
      if (cyc > 2000) begin
        chk(1'b0, tag, "request never completed", 32'(cyc), 32'h0);
        break;
      end
    end
    host_req_i = 1'b0;
    chk(host_err_o == exp_err, exp_err ? "R6" : tag, "host error flag",
        32'(host_err_o), 32'(exp_err));
    if (!we && !exp_err)
      chk(host_rdata_o == exp_rd, "R3", "read data", host_rdata_o, exp_rd);
    chk(n_seen == n_exp, "R8", "number of sub-accesses", 32'(n_seen), 32'(n_exp));
    if (!valid)
      chk(cyc == 2, "R7", "invalid model completion cycle", 32'(cyc), 32'd2);
    @(negedge clk);
    chk(!host_ack_o && !mdio_req_o, "R9", "ack pulse width / idle after ack",
        32'({host_ack_o, mdio_req_o}), 32'h0);
    op_active = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!host_ack_o, "R10", "host_ack_o in reset", 32'(host_ack_o), 32'h0);
    chk(!mdio_req_o, "R10", "mdio_req_o in reset", 32'(mdio_req_o), 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(!host_ack_o && !mdio_req_o, "R10", "idle after reset", 32'({host_ack_o, mdio_req_o}), 32'h0);

    host_op(18'h0010C, 32'h0, 1'b0, 2'd0, -1, 0, "R2", 1'b0);          // R2 R3 model A read
    host_op(18'h2F5C8, 32'h0, 1'b0, 2'd1, -1, 2, "R3", 1'b0);          // R3 model B read, waits
    host_op(18'h00040, 32'hDEAD_BEEF, 1'b1, 2'd0, -1, 1, "R4", 1'b0);  // R4 normal order
    host_op(18'h00098, 32'h1234_5678, 1'b1, 2'd0, -1, 1, "R5", 1'b0);  // R5 low first
    host_op(18'h00098, 32'hCAFE_F00D, 1'b1, 2'd1, -1, 0, "R5", 1'b0);  // R5 model B normal
    host_op(18'h00098, 32'h0, 1'b0, 2'd0, -1, 0, "R5", 1'b0);          // R5 read keeps order
    host_op(18'h3FFFF, 32'hA5A5_5A5A, 1'b1, 2'd1, -1, 3, "R1", 1'b0);  // R1 top page
    host_op(18'h00000, 32'h0000_0001, 1'b1, 2'd0, -1, 0, "R1", 1'b0);  // R1 page 0
    host_op(18'h00624, 32'h7F7F_7F7F, 1'b1, 2'd0, 0, 0, "R6", 1'b0);   // R6 page fails
    host_op(18'h0066C, 32'h0, 1'b0, 2'd1, 1, 1, "R6", 1'b0);           // R6 low half fails
    host_op(18'h00038, 32'hC000_050E, 1'b1, 2'd0, 2, 0, "R6", 1'b0);   // R6 last half fails
    host_op(18'h00104, 32'h4004, 1'b1, 2'd2, -1, 0, "R7", 1'b0);       // R7 invalid model
    host_op(18'h0005C, 32'h0, 1'b0, 2'd3, -1, 0, "R7", 1'b0);          // R7 invalid model
    host_op(18'h1ABCD, 32'h0, 1'b0, 2'd1, -1, 1, "R9", 1'b1);          // R9 inputs change mid-op
    host_op(18'h00070, 32'h0000_FA50, 1'b1, 2'd1, -1, 2, "R9", 1'b1);  // R9 write, inputs change
    host_op(18'h0010C, 32'h0, 1'b0, 2'd0, -1, 0, "R8", 1'b0);          // R8 recovery after errors

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule